// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the processor-side register file of a serial controller with a receive FIFO. A byte-addressed bus with a single-cycle access strobe reaches ten word-spaced registers. The bank holds the mode, baud, control, FIFO-control and port settings, each stored through its write mask. It keeps five status flags: transmit end, transmit data empty, break, receive full and data ready. It drives the transmit and receive interrupt lines.

The receive FIFO storage and the line shifter sit outside the bank. The bank exchanges strobes with them:

- A transmit-data write leaves as a one-cycle byte strobe.
- A receive-data read leaves as a pop strobe.
- A FIFO reset request leaves as a one-cycle pulse.
- Incoming bytes, line breaks and receive-idle events arrive as input pulses, together with the current FIFO occupancy.

Every access is registered. Read data appears one cycle after the access. All write side effects take hold at the same clock edge as the access.

Top module: `ser_reg_bank`

## Requirements
- R1: After reset the registers read as follows: mode reads 0, baud reads 0xFF, control reads 0x20 (transmit enable set), FIFO control reads 0, and port reads 0. Status reads 0x60, meaning transmit end and transmit data empty are set. Both interrupt outputs are low.
- R2: Offsets are mode 0x00, baud 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, FIFO count 0x1C, port 0x20 and line status 0x24. Writes are stored ANDed with a mask: 0x7B for mode, 0xFA for control and 0xF3 for port.
- R3: The status byte places transmit end at bit 6, transmit data empty at bit 5, break at bit 4, receive full at bit 1 and data ready at bit 0. A status write clears each of these flags whose written bit is 0 and leaves the flags written as 1 unchanged. A status write with bit 1 or bit 0 equal to 0 also drops `irq_rx`.
- R4: A control write with bit 5 (transmit enable) equal to 0 sets transmit end. Control bit 7 as written becomes `irq_tx`. A control write with bit 6 equal to 0 drops `irq_rx`.
- R5: A transmit-data write raises `tx_strobe` for exactly one cycle, with `tx_byte` equal to the written low byte. It also clears transmit data empty.
- R6: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets transmit data empty and transmit end.
- R7: FIFO control bits 7:6 select the receive trigger level: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14. An `rx_push` pulse whose `rx_count` is at or above the level sets receive full. If control bit 6 is 1, the same pulse also raises `irq_rx`.
- R8: A receive-data read with `rx_count` nonzero returns `rx_byte` and pulses `rx_pop` for one cycle. It clears receive full when `rx_count`-1 is below the trigger level. With `rx_count` zero the read returns 0 and gives no pop. The FIFO count register reads `rx_count`.
- R9: A `break_pulse` sets the break flag, which stays set until a status write clears it. An `idle_pulse` sets data ready in the same sticky way.
- R10: A FIFO-control write with bit 1 set pulses `fifo_reset` for one cycle and clears receive full. The written value reads back unchanged.
- R11: Line status reads 0 and ignores writes. An access to a misaligned offset or an offset above 0x24 reads 0, changes no register and pulses `bus_err` for one cycle.
- R12: `rd_valid` is high for exactly the cycle after each read access and is low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset |
| bus_wdata | input | DATA_W (16) | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W (16) | Read data |
| bus_err | output | 1 | Unmapped access pulse |
| tx_strobe | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_byte | input | 8 | Byte at the head of the external FIFO |
| rx_count | input | CNT_W (5) | External FIFO occupancy |
| rx_push | input | 1 | A byte entered the FIFO |
| rx_pop | output | 1 | Remove the head byte |
| fifo_reset | output | 1 | Empty the FIFO |
| break_pulse | input | 1 | Line break seen |
| idle_pulse | input | 1 | Receive idle with data present |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The assertions assume at most one bus access per cycle. They also assume that the event pulses do not land in the same cycle as a status write touching the same flag. The flag checks do not state a winner for that collision. The bench drives each access and each event pulse in its own two-cycle window and changes `rx_count` only between accesses, so the stimulus never produces such a collision. The occupancy presented with `rx_push` is taken to already include the pushed byte, and the bench follows that convention.

// File: rtl/ser_regs_pkg.sv
// Shared constants for the serial register bank: register indices
// (offset = index * 4), status bit positions, write masks, reset values.
package ser_regs_pkg;
    localparam int REG_MODE  = 0;
    localparam int REG_BAUD  = 1;
    localparam int REG_CTRL  = 2;
    localparam int REG_TXD   = 3;
    localparam int REG_STAT  = 4;
    localparam int REG_RXD   = 5;
    localparam int REG_FCTL  = 6;
    localparam int REG_FCNT  = 7;
    localparam int REG_PORT  = 8;
    localparam int REG_LSTAT = 9;
    localparam int NUM_REGS  = 10;

    localparam int ST_TEND = 6;
    localparam int ST_TDE  = 5;
    localparam int ST_BRK  = 4;
    localparam int ST_RDF  = 1;
    localparam int ST_DR   = 0;

    localparam int CTRL_TIE = 7;
    localparam int CTRL_RIE = 6;
    localparam int CTRL_TE  = 5;
    localparam int FCTL_CLR = 1;

    localparam logic [7:0] MODE_MASK = 8'h7B;
    localparam logic [7:0] CTRL_MASK = 8'hFA;
    localparam logic [7:0] PORT_MASK = 8'hF3;
    localparam logic [7:0] BAUD_RST  = 8'hFF;
    localparam logic [7:0] CTRL_RST  = 8'h20;
endpackage

// File: rtl/ser_bus_decode.sv
// Address decoder: turns a byte offset into a one-hot register select.
// Assumes registers sit on 4-byte boundaries starting at 0; anything
// misaligned or beyond the last register is reported as unmapped.
module ser_bus_decode #(
    parameter int ADDR_W = 6,
    parameter int NREGS  = 10
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREGS-1:0]  hit,
    output logic              unmapped
);
    // One comparator per register slot.
    for (genvar i = 0; i < NREGS; i++) begin : g_slot
        assign hit[i] = bus_sel && (bus_addr == ADDR_W'(i * 4));
    end

    // Selected but no slot matched.
    assign unmapped = bus_sel && (hit == '0);
endmodule

// File: rtl/ser_rx_trigger.sv
// Receive trigger compare: maps the 2-bit level code to 1/4/8/14 and
// compares the external FIFO occupancy against it, both as is and as it
// will be after one pop. Assumes CNT_W can hold the value 14.
module ser_rx_trigger #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       lvl_code,
    input  logic [CNT_W-1:0] count,
    output logic             at_level,
    output logic             below_after_pop
);
    logic [CNT_W-1:0] level;

    // Level code to byte count.
    always_comb begin
        case (lvl_code)
            2'd0:    level = CNT_W'(1);
            2'd1:    level = CNT_W'(4);
            2'd2:    level = CNT_W'(8);
            default: level = CNT_W'(14);
        endcase
    end

    // Compares now and after a pop.
    assign at_level        = (count >= level);
    assign below_after_pop = ((count - CNT_W'(1)) < level);
endmodule

// File: rtl/ser_status_flags.sv
// Status flags and receive interrupt. Flags clear only where a status
// write carries 0; hardware events set them after any clear in the same
// cycle. Assumes at most one bus access per cycle.
module ser_status_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stat,
    input  logic       rd_stat,
    input  logic       wr_ctrl,
    input  logic       wr_txd,
    input  logic       fifo_clr,
    input  logic [7:0] wbyte,
    input  logic       te,
    input  logic       rie,
    input  logic       rx_hit,
    input  logic       pop_below,
    input  logic       brk_in,
    input  logic       idle_in,
    output logic [7:0] status_byte,
    output logic       irq_rx
);
    import ser_regs_pkg::*;

    logic tend, tde, brk, rdf, dr;

    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tend <= 1'b1;
            tde  <= 1'b1;
            brk  <= 1'b0;
            rdf  <= 1'b0;
            dr   <= 1'b0;
        end else begin
            if (wr_stat) begin
                if (!wbyte[ST_TEND]) tend <= 1'b0;
                if (!wbyte[ST_TDE])  tde  <= 1'b0;
                if (!wbyte[ST_BRK])  brk  <= 1'b0;
                if (!wbyte[ST_RDF])  rdf  <= 1'b0;
                if (!wbyte[ST_DR])   dr   <= 1'b0;
            end
            if (wr_ctrl && !wbyte[CTRL_TE]) tend <= 1'b1;
            if (wr_txd) tde <= 1'b0;
            if (rd_stat && te) begin
                tde  <= 1'b1;
                tend <= 1'b1;
            end
            if (pop_below || fifo_clr) rdf <= 1'b0;
            if (rx_hit)  rdf <= 1'b1;
            if (brk_in)  brk <= 1'b1;
            if (idle_in) dr  <= 1'b1;
        end
    end

    // Receive interrupt: dropped by status/control writes, raised by trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx <= 1'b0;
        end else begin
            if ((wr_stat && (!wbyte[ST_RDF] || !wbyte[ST_DR])) ||
                (wr_ctrl && !wbyte[CTRL_RIE]))
                irq_rx <= 1'b0;
            if (rx_hit && rie) irq_rx <= 1'b1;
        end
    end

    // Pack flags into their bit positions.
    always_comb begin
        status_byte          = 8'h00;
        status_byte[ST_TEND] = tend;
        status_byte[ST_TDE]  = tde;
        status_byte[ST_BRK]  = brk;
        status_byte[ST_RDF]  = rdf;
        status_byte[ST_DR]   = dr;
    end

    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !(wr_stat && !wbyte[ST_BRK])) |=> brk); // R9
    AST_RDF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wbyte[ST_RDF] && !rx_hit) |=> !rdf); // R3
    AST_IRQ_RX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(rx_hit && rie)); // R7
    AST_STATUS_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && te) |=> (tde && tend)); // R6
endmodule

// File: rtl/ser_reg_bank.sv
// Processor-side register bank of a FIFO serial controller. Holds masked
// configuration registers, registers read data one cycle after the access,
// and turns data/FIFO accesses into one-cycle strobes for the external
// FIFO and shifter. Assumes one access per cycle and DATA_W >= 8.
module ser_reg_bank #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_err,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    input  logic [7:0]        rx_byte,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_push,
    output logic              rx_pop,
    output logic              fifo_reset,
    input  logic              break_pulse,
    input  logic              idle_pulse,
    output logic              irq_tx,
    output logic              irq_rx
);
    import ser_regs_pkg::*;

    localparam int NR = NUM_REGS;

    logic [NR-1:0]     hit, wr, rd;
    logic              unmapped;
    logic [7:0]        mode_q, baud_q, ctrl_q, port_q;
    logic [DATA_W-1:0] fctl_q, rd_mux;
    logic [7:0]        status_byte;
    logic              at_level, below_after_pop;
    logic              rx_nonempty, pop_now;

    ser_bus_decode #(.ADDR_W(ADDR_W), .NREGS(NR)) u_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .hit      (hit),
        .unmapped (unmapped)
    );

    assign wr = hit & {NR{bus_wr}};
    assign rd = hit & {NR{!bus_wr}};
    assign rx_nonempty = (rx_count != '0);
    assign pop_now     = rd[REG_RXD] && rx_nonempty;

    ser_rx_trigger #(.CNT_W(CNT_W)) u_trig (
        .lvl_code        (fctl_q[7:6]),
        .count           (rx_count),
        .at_level        (at_level),
        .below_after_pop (below_after_pop)
    );

    ser_status_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stat     (wr[REG_STAT]),
        .rd_stat     (rd[REG_STAT]),
        .wr_ctrl     (wr[REG_CTRL]),
        .wr_txd      (wr[REG_TXD]),
        .fifo_clr    (wr[REG_FCTL] && bus_wdata[FCTL_CLR]),
        .wbyte       (bus_wdata[7:0]),
        .te          (ctrl_q[CTRL_TE]),
        .rie         (ctrl_q[CTRL_RIE]),
        .rx_hit      (rx_push && at_level),
        .pop_below   (pop_now && below_after_pop),
        .brk_in      (break_pulse),
        .idle_in     (idle_pulse),
        .status_byte (status_byte),
        .irq_rx      (irq_rx)
    );

    // Configuration registers and transmit interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 8'h00;
            baud_q <= BAUD_RST;
            ctrl_q <= CTRL_RST;
            port_q <= 8'h00;
            fctl_q <= '0;
            irq_tx <= 1'b0;
        end else begin
            if (wr[REG_MODE]) mode_q <= bus_wdata[7:0] & MODE_MASK;
            if (wr[REG_BAUD]) baud_q <= bus_wdata[7:0];
            if (wr[REG_CTRL]) begin
                ctrl_q <= bus_wdata[7:0] & CTRL_MASK;
                irq_tx <= bus_wdata[CTRL_TIE];
            end
            if (wr[REG_PORT]) port_q <= bus_wdata[7:0] & PORT_MASK;
            if (wr[REG_FCTL]) fctl_q <= bus_wdata;
        end
    end

    // Read multiplexer (values before this cycle's update).
    always_comb begin
        rd_mux = '0;
        if (hit[REG_MODE]) rd_mux = DATA_W'(mode_q);
        if (hit[REG_BAUD]) rd_mux = DATA_W'(baud_q);
        if (hit[REG_CTRL]) rd_mux = DATA_W'(ctrl_q);
        if (hit[REG_STAT]) rd_mux = DATA_W'(status_byte);
        if (hit[REG_RXD] && rx_nonempty) rd_mux = DATA_W'(rx_byte);
        if (hit[REG_FCTL]) rd_mux = fctl_q;
        if (hit[REG_FCNT]) rd_mux = DATA_W'(rx_count);
        if (hit[REG_PORT]) rd_mux = DATA_W'(port_q);
    end

    // Registered read return and one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            bus_err    <= 1'b0;
            tx_strobe  <= 1'b0;
            tx_byte    <= 8'h00;
            rx_pop     <= 1'b0;
            fifo_reset <= 1'b0;
        end else begin
            rd_valid   <= bus_sel && !bus_wr;
            rd_data    <= (bus_sel && !bus_wr) ? rd_mux : '0;
            bus_err    <= unmapped;
            tx_strobe  <= wr[REG_TXD];
            if (wr[REG_TXD]) tx_byte <= bus_wdata[7:0];
            rx_pop     <= pop_now;
            fifo_reset <= wr[REG_FCTL] && bus_wdata[FCTL_CLR];
        end
    end

    AST_TX_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(wr[REG_TXD])); // R5
    AST_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel && unmapped)); // R11
    AST_RD_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_sel && !bus_wr)); // R12
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(rx_count != '0)); // R8
endmodule

// File: tb/ser_reg_bank_test.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue the expected word, a monitor pops and
// compares whenever rd_valid is seen; strobes and interrupts are checked
// directly after the edge that registers them.
module ser_reg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        rd_valid, bus_err, tx_strobe, rx_pop, fifo_reset, irq_tx, irq_rx;
    logic [15:0] rd_data;
    logic [7:0]  tx_byte;
    logic [7:0]  rx_byte = 8'h00;
    logic [4:0]  rx_count = '0;
    logic        rx_push = 1'b0, break_pulse = 1'b0, idle_pulse = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ser_reg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .bus_err(bus_err), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_count(rx_count),
        .rx_push(rx_push), .rx_pop(rx_pop), .fifo_reset(fifo_reset),
        .break_pulse(break_pulse), .idle_pulse(idle_pulse),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [5:0] a, logic [15:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic push_rx(logic [4:0] cnt);
        @(negedge clk);
        rx_count = cnt; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Monitor: compare each returned read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected rd_valid", 16'h1, 16'h0);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_tx", {15'h0, irq_tx}, 16'h0);
        chk("R1 irq_rx", {15'h0, irq_rx}, 16'h0);
        rd_reg(6'h00, 16'h0000, "R1 mode");
        rd_reg(6'h04, 16'h00FF, "R1 baud");
        rd_reg(6'h08, 16'h0020, "R1 control");
        rd_reg(6'h10, 16'h0060, "R1 status");
        rd_reg(6'h18, 16'h0000, "R1 fifo control");
        rd_reg(6'h20, 16'h0000, "R1 port");
        rd_reg(6'h1C, 16'h0000, "R8 count");
        // R2 masks, R4 tx interrupt
        wr_reg(6'h00, 16'h00FF);
        chk("R12 rd_valid after write", {15'h0, rd_valid}, 16'h0);
        rd_reg(6'h00, 16'h007B, "R2 mode mask");
        wr_reg(6'h08, 16'h00FF);
        chk("R4 irq_tx set", {15'h0, irq_tx}, 16'h1);
        rd_reg(6'h08, 16'h00FA, "R2 control mask");
        wr_reg(6'h20, 16'h00FF);
        rd_reg(6'h20, 16'h00F3, "R2 port mask");
        wr_reg(6'h04, 16'h0033);
        rd_reg(6'h04, 16'h0033, "R2 baud");
        // R5 transmit strobe; R6 rearm with TE=1
        wr_reg(6'h0C, 16'h005A);
        chk("R5 tx_strobe", {15'h0, tx_strobe}, 16'h1);
        chk("R5 tx_byte", {8'h0, tx_byte}, 16'h005A);
        @(negedge clk);
        chk("R5 strobe one cycle", {15'h0, tx_strobe}, 16'h0);
        rd_reg(6'h10, 16'h0040, "R5 R6 tde cleared");
        rd_reg(6'h10, 16'h0060, "R6 rearmed");
        // R4 TE=0 sets TEND; R6 no rearm
        wr_reg(6'h08, 16'h0000);
        chk("R4 irq_tx clear", {15'h0, irq_tx}, 16'h0);
        wr_reg(6'h10, 16'h00BF);
        rd_reg(6'h10, 16'h0020, "R3 tend cleared");
        wr_reg(6'h08, 16'h0000);
        rd_reg(6'h10, 16'h0060, "R4 te=0 sets tend");
        wr_reg(6'h0C, 16'h0011);
        rd_reg(6'h10, 16'h0040, "R6 read");
        rd_reg(6'h10, 16'h0040, "R6 no rearm when te=0");
        // R9 break sticky; R3 write-1 keeps, write-0 clears
        @(negedge clk); break_pulse = 1'b1;
        @(negedge clk); break_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rd_reg(6'h10, 16'h0050, "R9 break set");
        wr_reg(6'h10, 16'h00FF);
        rd_reg(6'h10, 16'h0050, "R3 ones keep flags");
        wr_reg(6'h10, 16'h00EF);
        rd_reg(6'h10, 16'h0040, "R3 break cleared");
        @(negedge clk); idle_pulse = 1'b1;
        @(negedge clk); idle_pulse = 1'b0;
        rd_reg(6'h10, 16'h0041, "R9 data ready set");
        // R7 trigger 4 with RIE
        wr_reg(6'h08, 16'h0040);
        wr_reg(6'h18, 16'h0040);
        push_rx(5'd3);
        chk("R7 below level irq", {15'h0, irq_rx}, 16'h0);
        rd_reg(6'h10, 16'h0041, "R7 below level");
        push_rx(5'd4);
        chk("R7 irq_rx raised", {15'h0, irq_rx}, 16'h1);
        rd_reg(6'h10, 16'h0043, "R7 rdf set at 4");
        // R8 receive read
        rx_byte = 8'hA5;
        rd_reg(6'h14, 16'h00A5, "R8 rx byte");
        chk("R8 rx_pop", {15'h0, rx_pop}, 16'h1);
        @(negedge clk);
        chk("R8 pop one cycle", {15'h0, rx_pop}, 16'h0);
        rd_reg(6'h10, 16'h0041, "R8 rdf cleared by pop");
        chk("R8 irq kept after pop", {15'h0, irq_rx}, 16'h1);
        wr_reg(6'h10, 16'h00FE);
        chk("R3 irq_rx dropped", {15'h0, irq_rx}, 16'h0);
        rd_reg(6'h10, 16'h0040, "R3 dr cleared");
        rx_count = 5'd7;
        rd_reg(6'h1C, 16'h0007, "R8 count reg");
        rx_count = 5'd0;
        rd_reg(6'h14, 16'h0000, "R8 empty read");
        chk("R8 no pop when empty", {15'h0, rx_pop}, 16'h0);
        // R10 FIFO reset
        wr_reg(6'h18, 16'h0000);
        push_rx(5'd1);
        rd_reg(6'h10, 16'h0042, "R7 level 1");
        wr_reg(6'h18, 16'h0002);
        chk("R10 fifo_reset", {15'h0, fifo_reset}, 16'h1);
        rd_reg(6'h10, 16'h0040, "R10 rdf cleared");
        rd_reg(6'h18, 16'h0002, "R10 readback");
        chk("R10 pulse one cycle", {15'h0, fifo_reset}, 16'h0);
        // R4 RIE=0 drops irq_rx
        chk("R4 irq_rx before", {15'h0, irq_rx}, 16'h1);
        wr_reg(6'h08, 16'h0000);
        chk("R4 irq_rx dropped", {15'h0, irq_rx}, 16'h0);
        // R7 levels 8 and 14, no interrupt with RIE=0
        wr_reg(6'h18, 16'h0080);
        push_rx(5'd7);
        rd_reg(6'h10, 16'h0040, "R7 level 8 below");
        push_rx(5'd8);
        rd_reg(6'h10, 16'h0042, "R7 level 8 hit");
        chk("R7 no irq when rie=0", {15'h0, irq_rx}, 16'h0);
        wr_reg(6'h10, 16'h00FD);
        wr_reg(6'h18, 16'h00C0);
        push_rx(5'd13);
        rd_reg(6'h10, 16'h0040, "R7 level 14 below");
        push_rx(5'd14);
        rd_reg(6'h10, 16'h0042, "R7 level 14 hit");
        // R11 line status and unmapped
        wr_reg(6'h24, 16'h00FF);
        chk("R11 lstat no error", {15'h0, bus_err}, 16'h0);
        rd_reg(6'h24, 16'h0000, "R11 line status");
        wr_reg(6'h28, 16'h00FF);
        chk("R11 err unmapped write", {15'h0, bus_err}, 16'h1);
        wr_reg(6'h01, 16'h0000);
        chk("R11 err misaligned", {15'h0, bus_err}, 16'h1);
        rd_reg(6'h00, 16'h007B, "R11 mode untouched");
        rd_reg(6'h2C, 16'h0000, "R11 unmapped read");
        chk("R11 err unmapped read", {15'h0, bus_err}, 16'h1);
        @(negedge clk);
        chk("R12 rd_valid low", {15'h0, rd_valid}, 16'h0);
        repeat (3) @(negedge clk);
        chk("R12 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule